// File: doc/BRIEF.md
# Delayed Store Write Buffer

This block sits between the memory stage of a pipeline and the data RAM of a cache, so that a store needs only one cycle in that stage. In a store's own cycle only the tag lookup runs. A store that hits is parked in a single-entry holding register, which keeps its word address, data and byte mask. The parked data reaches the RAM later, in the cycle of the next store that hits. The RAM is idle during that cycle because a store does not read it.

A load whose word address matches the parked entry takes those bytes from the holding register and the other bytes from the RAM. The value it sees is therefore always the architecturally current one. An explicit flush request writes the parked store into the RAM during an idle cycle and empties the holding register.

The controller has two states. `SB_EMPTY` means nothing is parked and `SB_HELD` means one store is parked. There are four transitions:
- **capture**: `SB_EMPTY` to `SB_HELD` on a store hit.
- **swap**: `SB_HELD` to `SB_HELD` on a store hit. The old entry is drained and the new one captured in the same cycle.
- **retire**: `SB_HELD` to `SB_EMPTY` on a flush in an idle cycle.
- **hold**: the state is kept in every other case.

Top module: `store_defer_buf`

## Requirements
- R1: A store with `tag_hit` high while the buffer is empty causes no RAM write in its cycle (`ram_we` low). From the next cycle on, loads to its address see its data.
- R2: A store with `tag_hit` high while a store is parked drives `ram_we` high in that same cycle, with `ram_addr`, `ram_wdata` and `ram_wbe` carrying the parked entry. Afterwards the buffer holds the new store.
- R3: A load (`req_valid` high, `req_is_store` low) whose `req_addr` equals the parked address raises `load_fwd`. For byte lane k (bits 8k+7:8k), `load_data` takes that lane from the parked data where parked mask bit k is 1, and from `ram_rdata` where it is 0.
- R4: A load with a different address, or a load while the buffer is empty, returns `ram_rdata` unchanged, with `load_fwd` low.
- R5: A store with `tag_hit` low raises `store_miss` in that cycle. It writes nothing to the RAM and leaves the parked entry unchanged.
- R6: A flush in a cycle with `req_valid` low drives one RAM write of the parked entry when one exists. The buffer is empty afterwards, and a flush with nothing parked writes nothing.
- R7: A flush in the same cycle as a load is ignored. A flush in the same cycle as a store acts exactly as that store alone would.
- R8: Reset empties the buffer. After reset, loads see RAM data and a flush writes nothing.
- R9: Outside a drain cycle, `ram_addr` follows `req_addr` and `ram_we` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Memory-stage request present |
| req_is_store | input | 1 | 1 = store, 0 = load |
| req_addr | input | AW | Word address of the request |
| req_wdata | input | DW | Store data |
| req_be | input | DW/8 | Store byte mask |
| tag_hit | input | 1 | Tag-check result for the current request |
| flush | input | 1 | Drain request for the parked store |
| store_miss | output | 1 | Current store missed in the tags |
| load_data | output | DW | Load result, merged with parked bytes |
| load_fwd | output | 1 | Load took at least its address match from the buffer |
| ram_addr | output | AW | Data RAM word address |
| ram_we | output | 1 | Data RAM write strobe |
| ram_wbe | output | DW/8 | Data RAM byte write mask |
| ram_wdata | output | DW | Data RAM write data |
| ram_rdata | input | DW | Data RAM asynchronous read data |

## Verification
The bench builds the block with a 4-bit word address and 16-bit data. With 16 words, the bench can keep a full byte-writable RAM model with an asynchronous read. The two byte lanes make every mask value reachable: both lanes, only the low lane, only the high lane. Each partial mask is merged in both directions, and each drain carries a mask the bench can verify by reading the word back.

// File: rtl/sdb_pkg.sv
package sdb_pkg;
    typedef enum logic {
        SB_EMPTY = 1'b0,
        SB_HELD  = 1'b1
    } sb_state_e;
endpackage

// File: rtl/sdb_ctrl.sv
module sdb_ctrl
    import sdb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic req_is_store,
    input  logic tag_hit,
    input  logic flush,
    output logic capture,
    output logic drain,
    output logic store_miss,
    output logic held
);
    sb_state_e state_q, state_d;
    logic      st_hit;
    logic      idle_flush;

    assign st_hit     = req_valid && req_is_store && tag_hit;
    assign idle_flush = !req_valid && flush;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SB_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SB_EMPTY: if (st_hit) state_d = SB_HELD;            // capture
            SB_HELD: begin
                if (st_hit)          state_d = SB_HELD;         // swap
                else if (idle_flush) state_d = SB_EMPTY;        // retire
            end
            default: state_d = SB_EMPTY;
        endcase
    end

    always_comb begin
        capture    = st_hit;
        store_miss = req_valid && req_is_store && !tag_hit;
        held       = (state_q == SB_HELD);
        drain      = 1'b0;
        unique case (state_q)
            SB_EMPTY: drain = 1'b0;
            SB_HELD:  drain = st_hit || idle_flush;
            default:  drain = 1'b0;
        endcase
    end
endmodule

// File: rtl/sdb_entry.sv
module sdb_entry #(
    parameter int AW = 10,
    parameter int DW = 32,
    localparam int BW = DW / 8
) (
    input  logic          clk,
    input  logic          capture,
    input  logic [AW-1:0] in_addr,
    input  logic [DW-1:0] in_data,
    input  logic [BW-1:0] in_be,
    output logic [AW-1:0] q_addr,
    output logic [DW-1:0] q_data,
    output logic [BW-1:0] q_be
);
    always_ff @(posedge clk) begin
        if (capture) begin
            q_addr <= in_addr;
            q_data <= in_data;
            q_be   <= in_be;
        end
    end
endmodule

// File: rtl/sdb_merge.sv
module sdb_merge #(
    parameter int AW = 10,
    parameter int DW = 32,
    localparam int BW = DW / 8
) (
    input  logic          held,
    input  logic          is_load,
    input  logic [AW-1:0] req_addr,
    input  logic [AW-1:0] buf_addr,
    input  logic [DW-1:0] buf_data,
    input  logic [BW-1:0] buf_be,
    input  logic [DW-1:0] ram_rdata,
    output logic [DW-1:0] load_data,
    output logic          load_fwd
);
    logic match;
    assign match    = held && is_load && (req_addr == buf_addr);
    assign load_fwd = match;

    for (genvar k = 0; k < BW; k++) begin : g_lane
        assign load_data[8*k +: 8] = (match && buf_be[k]) ? buf_data[8*k +: 8]
                                                           : ram_rdata[8*k +: 8];
    end
endmodule

// File: rtl/store_defer_buf.sv
module store_defer_buf #(
    parameter int AW = 10,
    parameter int DW = 32,
    localparam int BW = DW / 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_is_store,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic [BW-1:0] req_be,
    input  logic          tag_hit,
    input  logic          flush,
    output logic          store_miss,
    output logic [DW-1:0] load_data,
    output logic          load_fwd,
    output logic [AW-1:0] ram_addr,
    output logic          ram_we,
    output logic [BW-1:0] ram_wbe,
    output logic [DW-1:0] ram_wdata,
    input  logic [DW-1:0] ram_rdata
);
    logic          capture;
    logic          drain;
    logic          held;
    logic [AW-1:0] buf_addr;
    logic [DW-1:0] buf_data;
    logic [BW-1:0] buf_be;

    sdb_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_is_store (req_is_store),
        .tag_hit      (tag_hit),
        .flush        (flush),
        .capture      (capture),
        .drain        (drain),
        .store_miss   (store_miss),
        .held         (held)
    );

    sdb_entry #(.AW(AW), .DW(DW)) u_entry (
        .clk     (clk),
        .capture (capture),
        .in_addr (req_addr),
        .in_data (req_wdata),
        .in_be   (req_be),
        .q_addr  (buf_addr),
        .q_data  (buf_data),
        .q_be    (buf_be)
    );

    sdb_merge #(.AW(AW), .DW(DW)) u_merge (
        .held      (held),
        .is_load   (req_valid && !req_is_store),
        .req_addr  (req_addr),
        .buf_addr  (buf_addr),
        .buf_data  (buf_data),
        .buf_be    (buf_be),
        .ram_rdata (ram_rdata),
        .load_data (load_data),
        .load_fwd  (load_fwd)
    );

    assign ram_we    = drain;
    assign ram_addr  = drain ? buf_addr : req_addr;
    assign ram_wdata = buf_data;
    assign ram_wbe   = drain ? buf_be : '0;
endmodule

// File: rtl/sdb_chk.sv
module sdb_chk #(
    parameter int AW = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_is_store,
    input logic          tag_hit,
    input logic          flush,
    input logic          store_miss,
    input logic          ram_we,
    input logic          load_fwd,
    input logic          held,
    input logic [AW-1:0] buf_addr
);
    // R1
    store_hit_parks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_is_store && tag_hit) |=> held);

    // R2
    write_needs_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> held);

    // R3
    fwd_only_on_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_fwd |-> (req_valid && !req_is_store && held));

    // R5
    miss_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        store_miss |-> !ram_we);

    // R5
    miss_keeps_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (store_miss && held) |=> (held && $stable(buf_addr)));

    // R6
    flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_valid && flush) |=> !held);

    // R7
    load_flush_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_is_store && flush) |-> !ram_we);
endmodule

bind store_defer_buf sdb_chk #(.AW(AW)) u_sdb_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_is_store (req_is_store),
    .tag_hit      (tag_hit),
    .flush        (flush),
    .store_miss   (store_miss),
    .ram_we       (ram_we),
    .load_fwd     (load_fwd),
    .held         (held),
    .buf_addr     (buf_addr)
);

// File: tb/tb_store_defer_buf.sv
module tb_store_defer_buf;
    localparam int AW = 4;
    localparam int DW = 16;
    localparam int BW = DW / 8;
    localparam int VW = 49;
    localparam int NV = 18;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_is_store = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic [BW-1:0] req_be = '0;
    logic          tag_hit = 1'b0;
    logic          flush = 1'b0;
    logic          store_miss;
    logic [DW-1:0] load_data;
    logic          load_fwd;
    logic [AW-1:0] ram_addr;
    logic          ram_we;
    logic [BW-1:0] ram_wbe;
    logic [DW-1:0] ram_wdata;
    logic [DW-1:0] ram_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [DW-1:0] mem [1<<AW];

    always #4 clk = ~clk;

    store_defer_buf #(.AW(AW), .DW(DW)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_is_store(req_is_store),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be), .tag_hit(tag_hit),
        .flush(flush), .store_miss(store_miss), .load_data(load_data), .load_fwd(load_fwd),
        .ram_addr(ram_addr), .ram_we(ram_we), .ram_wbe(ram_wbe), .ram_wdata(ram_wdata),
        .ram_rdata(ram_rdata)
    );

    assign ram_rdata = mem[ram_addr];

    always_ff @(posedge clk) begin
        if (ram_we) begin
            for (int k = 0; k < BW; k++)
                if (ram_wbe[k]) mem[ram_addr][8*k +: 8] <= ram_wdata[8*k +: 8];
        end
    end

    // op: 0 idle, 1 load, 2 store
    function automatic logic [VW-1:0] mk(input logic [1:0] op, input logic hit, input logic fl,
                                         input logic [3:0] a, input logic [1:0] be,
                                         input logic [15:0] wd, input logic we,
                                         input logic [3:0] wa, input logic ms,
                                         input logic fw, input logic [15:0] d);
        return {op, hit, fl, a, be, wd, we, wa, ms, fw, d};
    endfunction

    localparam logic [VW-1:0] VEC [NV] = '{
        mk(2'd1, 1'b0, 1'b0, 4'd3, 2'b00, 16'h0000, 1'b0, 4'd0, 1'b0, 1'b0, 16'hA353), // R4 empty
        mk(2'd2, 1'b1, 1'b0, 4'd3, 2'b11, 16'h1234, 1'b0, 4'd0, 1'b0, 1'b0, 16'h0000), // R1
        mk(2'd1, 1'b0, 1'b0, 4'd3, 2'b00, 16'h0000, 1'b0, 4'd0, 1'b0, 1'b1, 16'h1234), // R3 full
        mk(2'd1, 1'b0, 1'b0, 4'd4, 2'b00, 16'h0000, 1'b0, 4'd0, 1'b0, 1'b0, 16'hA454), // R4 mismatch
        mk(2'd2, 1'b1, 1'b0, 4'd5, 2'b01, 16'hBEEF, 1'b1, 4'd3, 1'b0, 1'b0, 16'h0000), // R2 swap
        mk(2'd1, 1'b0, 1'b0, 4'd3, 2'b00, 16'h0000, 1'b0, 4'd0, 1'b0, 1'b0, 16'h1234), // R2 drained
        mk(2'd1, 1'b0, 1'b0, 4'd5, 2'b00, 16'h0000, 1'b0, 4'd0, 1'b0, 1'b1, 16'hA5EF), // R3 low lane
        mk(2'd2, 1'b0, 1'b0, 4'd6, 2'b10, 16'h7788, 1'b0, 4'd0, 1'b1, 1'b0, 16'h0000), // R5 miss
        mk(2'd1, 1'b0, 1'b0, 4'd5, 2'b00, 16'h0000, 1'b0, 4'd0, 1'b0, 1'b1, 16'hA5EF), // R5 kept
        mk(2'd1, 1'b0, 1'b0, 4'd6, 2'b00, 16'h0000, 1'b0, 4'd0, 1'b0, 1'b0, 16'hA656), // R5 no write
        mk(2'd0, 1'b0, 1'b1, 4'd0, 2'b00, 16'h0000, 1'b1, 4'd5, 1'b0, 1'b0, 16'h0000), // R6 flush
        mk(2'd1, 1'b0, 1'b0, 4'd5, 2'b00, 16'h0000, 1'b0, 4'd0, 1'b0, 1'b0, 16'hA5EF), // R6 empty
        mk(2'd0, 1'b0, 1'b1, 4'd0, 2'b00, 16'h0000, 1'b0, 4'd0, 1'b0, 1'b0, 16'h0000), // R6 no entry
        mk(2'd2, 1'b1, 1'b0, 4'd7, 2'b10, 16'h3300, 1'b0, 4'd0, 1'b0, 1'b0, 16'h0000), // R1
        mk(2'd1, 1'b0, 1'b1, 4'd7, 2'b00, 16'h0000, 1'b0, 4'd0, 1'b0, 1'b1, 16'h3357), // R7 load+flush
        mk(2'd2, 1'b1, 1'b1, 4'd8, 2'b11, 16'h9999, 1'b1, 4'd7, 1'b0, 1'b0, 16'h0000), // R7 store+flush
        mk(2'd1, 1'b0, 1'b0, 4'd8, 2'b00, 16'h0000, 1'b0, 4'd0, 1'b0, 1'b1, 16'h9999), // R3
        mk(2'd1, 1'b0, 1'b0, 4'd7, 2'b00, 16'h0000, 1'b0, 4'd0, 1'b0, 1'b0, 16'h3357)  // R9 readback
    };

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [1:0] op, input logic hit, input logic fl,
                         input logic [3:0] a, input logic [1:0] be, input logic [15:0] wd);
        req_valid    = (op != 2'd0);
        req_is_store = (op == 2'd2);
        tag_hit      = hit;
        flush        = fl;
        req_addr     = a;
        req_be       = be;
        req_wdata    = wd;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        finish_run();
    end

    initial begin
        for (int i = 0; i < (1 << AW); i++)
            mem[i] = {4'hA, i[3:0], 4'h5, i[3:0]};

        // R8 reset state: a flush during reset writes nothing
        drive(2'd0, 1'b0, 1'b1, 4'd0, 2'b00, 16'h0);
        repeat (3) @(posedge clk);
        #1;
        check(ram_we == 1'b0, "R8 reset no write", 32'(ram_we), 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(ram_we == 1'b0, "R8 flush after reset", 32'(ram_we), 32'h0);

        for (int v = 0; v < NV; v++) begin
            logic [VW-1:0] e;
            e = VEC[v];
            @(negedge clk);
            drive(e[48:47], e[46], e[45], e[44:41], e[40:39], e[38:23]);
            #1;
            check(ram_we == e[22], $sformatf("R2/R6 vec%0d ram_we", v), 32'(ram_we), 32'(e[22]));
            if (e[22])
                check(ram_addr == e[21:18], $sformatf("R2 vec%0d ram_addr", v),
                      32'(ram_addr), 32'(e[21:18]));
            else
                check(ram_addr == e[44:41], $sformatf("R9 vec%0d ram_addr", v),
                      32'(ram_addr), 32'(e[44:41]));
            check(store_miss == e[17], $sformatf("R5 vec%0d store_miss", v),
                  32'(store_miss), 32'(e[17]));
            check(load_fwd == e[16], $sformatf("R3/R4 vec%0d load_fwd", v),
                  32'(load_fwd), 32'(e[16]));
            if (e[48:47] == 2'd1)
                check(load_data == e[15:0], $sformatf("R3/R4 vec%0d load_data", v),
                      32'(load_data), 32'(e[15:0]));
        end

        // R8: reset while a store is parked discards it
        @(negedge clk);
        drive(2'd2, 1'b1, 1'b0, 4'd9, 2'b11, 16'hFFFF);
        #1;
        check(ram_we == 1'b1, "R2 drain before reset", 32'(ram_we), 32'h1);
        @(negedge clk);
        drive(2'd0, 1'b0, 1'b0, 4'd0, 2'b00, 16'h0);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        drive(2'd1, 1'b0, 1'b0, 4'd9, 2'b00, 16'h0);
        #1;
        check(load_data == 16'hA959, "R8 load after reset", 32'(load_data), 32'hA959);
        check(load_fwd == 1'b0, "R8 no forward after reset", 32'(load_fwd), 32'h0);
        @(negedge clk);
        drive(2'd0, 1'b0, 1'b1, 4'd0, 2'b00, 16'h0);
        #1;
        check(ram_we == 1'b0, "R8 flush empty after reset", 32'(ram_we), 32'h0);

        // R2 mask on drain: park high-lane store, swap, verify drained lane only
        @(negedge clk);
        drive(2'd2, 1'b1, 1'b0, 4'd10, 2'b10, 16'h4411);
        @(negedge clk);
        drive(2'd2, 1'b1, 1'b0, 4'd11, 2'b01, 16'h2266);
        #1;
        check(ram_wbe == 2'b10, "R2 drain mask", 32'(ram_wbe), 32'h2);
        check(ram_wdata[15:8] == 8'h44, "R2 drain data", 32'(ram_wdata[15:8]), 32'h44);
        @(negedge clk);
        drive(2'd1, 1'b0, 1'b0, 4'd10, 2'b00, 16'h0);
        #1;
        check(load_data == 16'h445A, "R2 drained word", 32'(load_data), 32'h445A);
        @(negedge clk);
        drive(2'd1, 1'b0, 1'b0, 4'd11, 2'b00, 16'h0);
        #1;
        check(load_data == 16'hAB66, "R3 low-lane merge", 32'(load_data), 32'hAB66);

        @(negedge clk);
        drive(2'd0, 1'b0, 1'b0, 4'd0, 2'b00, 16'h0);
        @(negedge clk);
        finish_run();
    end
endmodule